// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error-Tagged FIFO and Break Detection

This block receives characters from one asynchronous serial line. The line is sampled on a 16x oversampling clock enable supplied from outside. The character format is chosen at run time: 7 or 8 data bits, 1 or 2 stop bits, and even, odd or no parity. Each character that completes is written into a 64-entry receive queue. Every queue entry carries the received byte and that character's own parity-error and framing-error tags. The queue is read through a show-ahead port that reports its fill level, empty and full.

The receiver also keeps a sticky overrun flag and detects a break, which is a low line that outlasts a whole frame after a framing error. It drives an active-low ready-to-send output for flow control, and it passes the raw line level straight through as a status bit.

The deframer is a state machine with eight states:
- IDLE waits for a low sample.
- START confirms the start bit at mid-bit. It goes back to IDLE on a high sample (glitch) or moves on to DATA.
- DATA shifts in the data bits, LSB first. It moves to PARITY when parity is enabled, otherwise to STOP1.
- PARITY moves to STOP1.
- STOP1 moves to STOP2 in two-stop mode. Otherwise the character completes and the machine goes to IDLE, or to HUNT when the stop bit was low.
- STOP2 completes the character and goes to IDLE, or to HUNT on a framing error.
- HUNT counts low ticks. It goes back to IDLE as soon as the line is high, and to BREAK once the low time exceeds one frame.
- BREAK leaves to IDLE after the line has been high for one full bit time.

Top module: `serial_rx_channel`

## Requirements
- R1: When cfg_seven=0 a character has 8 data bits; when cfg_seven=1 it has 7 data bits. Data bits arrive LSB first. In 7-bit mode the stored byte has bit 7 equal to 0.
- R2: When cfg_two_stop=0 a character has one stop bit; when cfg_two_stop=1 it has two. If any stop bit sampled at mid-bit is low, the entry's rd_frm_err is 1; otherwise it is 0.
- R3: When cfg_par_en=1, one parity bit follows the data bits. cfg_par_odd=0 selects even parity, where data ones plus the parity bit is an even count; cfg_par_odd=1 selects odd parity. A mismatch sets that entry's rd_par_err. With cfg_par_en=0 there is no parity bit and rd_par_err is 0.
- R4: The queue holds 64 entries in arrival order. rd_data, rd_par_err and rd_frm_err always show the oldest entry. rd_en removes that entry. rx_level counts the entries, rx_full is 1 at 64 entries, and rd_en while the queue is empty does nothing.
- R5: A character that completes while the queue is full is discarded and sets overrun. overrun stays 1 until ovr_clr is pulsed.
- R6: break_det rises after a framing error when the line then stays low for longer than one frame at the current format, where one frame is start + data + parity + stop bits. A shorter low does not raise it. While break_det is 1 no character is queued. break_det falls after the line has been high for one bit time, and reception then resumes.
- R7: rts_n is 1 when rx_level is 60 or more, and 0 below 60.
- R8: rxd_raw equals the rxd input at all times, without passing through the deframer.
- R9: A low pulse that is high again at the start bit's mid-point (sample 8 of 16) is rejected and queues nothing.
- R10: After reset the queue is empty, rx_level is 0, and rts_n, overrun and break_det are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial data line |
| cfg_seven | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest entry's byte |
| rd_par_err | output | 1 | Oldest entry's parity error tag |
| rd_frm_err | output | 1 | Oldest entry's framing error tag |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |
| rx_level | output | 7 | Number of queued entries |
| ovr_clr | input | 1 | Clear the overrun flag |
| overrun | output | 1 | Sticky overrun flag |
| break_det | output | 1 | Break in progress |
| rxd_raw | output | 1 | Unsynchronized line level |
| rts_n | output | 1 | Ready-to-send, active low |

## Verification
The bench aims at the points where the formats diverge.

A 7-bit character sent with a high bit 7 shows whether bit 7 is forced to zero. A design that shifts the wrong number of bits would store a shifted byte and take the parity bit as data.

A bad first stop bit in two-stop mode must still tag the entry. A design that checks only the last stop bit would miss it.

Break tests hold the line low just under and just over one frame in two formats of different length. A design with a fixed frame time would report a break too early or too late.

Filling the queue to 64 and beyond checks two things. The ready-to-send output must turn at 60. Extra characters must be dropped while overrun stays set. A design that wrote into a full queue would corrupt the oldest entry, which the drain then catches.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_HUNT,
        ST_BREAK
    } rx_state_e;

    typedef struct packed {
        logic       par_err;
        logic       frm_err;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/srx_sync.sv
`timescale 1ns/1ps
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
`timescale 1ns/1ps
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rxd,
    input  logic      seven,
    input  logic      two_stop,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      ent_valid,
    output rx_entry_t ent,
    output logic      brk_active
);
    localparam int CW = $clog2(OVS);
    localparam int FW = $clog2(12 * OVS + 1) + 1;
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e     st_q, st_d;
    logic [CW-1:0] tc_q;
    logic [2:0]    bi_q;
    logic [7:0]    sh_q;
    logic          xa_q, pe_q, fe_q;
    logic [FW-1:0] low_q;
    logic [CW-1:0] hi_q;
    logic [3:0]    nbits;
    logic [FW-1:0] frame_len;
    logic          last_bit, at_edge, done;

    always_comb begin
        nbits     = 4'd2 + (seven ? 4'd7 : 4'd8) + {3'b0, par_en} + {3'b0, two_stop};
        frame_len = FW'(nbits) * FW'(OVS);
        last_bit  = (bi_q == (seven ? 3'd6 : 3'd7));
        at_edge   = tick && (tc_q == LAST);
        done      = at_edge && ((st_q == ST_STOP1 && !two_stop) || st_q == ST_STOP2);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (tick) begin
            unique case (st_q)
                ST_IDLE:   if (!rxd) st_d = ST_START;
                ST_START:  if (tc_q == MID) st_d = rxd ? ST_IDLE : ST_DATA;
                ST_DATA:   if (tc_q == LAST && last_bit) st_d = par_en ? ST_PARITY : ST_STOP1;
                ST_PARITY: if (tc_q == LAST) st_d = ST_STOP1;
                ST_STOP1: begin
                    if (tc_q == LAST) begin
                        if (two_stop) st_d = ST_STOP2;
                        else          st_d = rxd ? ST_IDLE : ST_HUNT;
                    end
                end
                ST_STOP2:  if (tc_q == LAST) st_d = (rxd && !fe_q) ? ST_IDLE : ST_HUNT;
                ST_HUNT: begin
                    if (rxd)                    st_d = ST_IDLE;
                    else if (low_q >= frame_len) st_d = ST_BREAK;
                end
                ST_BREAK:  if (rxd && hi_q == LAST) st_d = ST_IDLE;
            endcase
        end
    end

    // bit timing and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q  <= '0;
            bi_q  <= '0;
            sh_q  <= '0;
            xa_q  <= 1'b0;
            pe_q  <= 1'b0;
            fe_q  <= 1'b0;
            low_q <= '0;
            hi_q  <= '0;
        end else if (tick) begin
            case (st_q)
                ST_START: begin
                    tc_q <= (tc_q == MID) ? '0 : tc_q + 1'b1;
                    bi_q <= '0;
                    xa_q <= 1'b0;
                    pe_q <= 1'b0;
                    fe_q <= 1'b0;
                end
                ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2:
                    tc_q <= (tc_q == LAST) ? '0 : tc_q + 1'b1;
                default: tc_q <= '0;
            endcase
            if (tc_q == LAST) begin
                case (st_q)
                    ST_DATA: begin
                        sh_q <= {rxd, sh_q[7:1]};
                        xa_q <= xa_q ^ rxd;
                        bi_q <= bi_q + 3'd1;
                    end
                    ST_PARITY: pe_q <= (rxd != (xa_q ^ par_odd));
                    ST_STOP1:  fe_q <= !rxd;
                    default:   fe_q <= fe_q;
                endcase
            end
            low_q <= (st_q == ST_HUNT && !rxd) ? low_q + 1'b1 : '0;
            hi_q  <= (st_q == ST_BREAK && rxd) ? hi_q + 1'b1 : '0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid  <= 1'b0;
            ent        <= '0;
            brk_active <= 1'b0;
        end else begin
            ent_valid   <= done;
            ent.data    <= seven ? {1'b0, sh_q[7:1]} : sh_q;
            ent.frm_err <= ((st_q == ST_STOP2) && fe_q) || !rxd;
            ent.par_err <= pe_q && par_en;
            brk_active  <= (st_d == ST_BREAK);
        end
    end
endmodule

// File: rtl/srx_fifo.sv
`timescale 1ns/1ps
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  rx_entry_t                wdata,
    input  logic                     pop,
    output rx_entry_t                rdata,
    output logic [$clog2(DEPTH):0]   level,
    output logic                     empty,
    output logic                     full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    rx_entry_t   mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == TOP) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == TOP) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/serial_rx_channel.sv
`timescale 1ns/1ps
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DEPTH       = 64,
    parameter int RTS_LEVEL   = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_16x,
    input  logic                   rxd,
    input  logic                   cfg_seven,
    input  logic                   cfg_two_stop,
    input  logic                   cfg_par_en,
    input  logic                   cfg_par_odd,
    input  logic                   rd_en,
    output logic [7:0]             rd_data,
    output logic                   rd_par_err,
    output logic                   rd_frm_err,
    output logic                   rx_empty,
    output logic                   rx_full,
    output logic [$clog2(DEPTH):0] rx_level,
    input  logic                   ovr_clr,
    output logic                   overrun,
    output logic                   break_det,
    output logic                   rxd_raw,
    output logic                   rts_n
);
    localparam int LW = $clog2(DEPTH) + 1;

    logic      rxd_s;
    logic      ent_valid;
    rx_entry_t ent, head;
    logic      push;

    srx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s)
    );

    srx_deframer #(.OVS(OVS)) deframer_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_16x), .rxd(rxd_s),
        .seven(cfg_seven), .two_stop(cfg_two_stop),
        .par_en(cfg_par_en), .par_odd(cfg_par_odd),
        .ent_valid(ent_valid), .ent(ent), .brk_active(break_det)
    );

    assign push = ent_valid && !rx_full;

    srx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(ent), .pop(rd_en),
        .rdata(head), .level(rx_level), .empty(rx_empty), .full(rx_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    overrun <= 1'b0;
        else if (ent_valid && rx_full) overrun <= 1'b1;
        else if (ovr_clr)              overrun <= 1'b0;
    end

    assign rd_data    = head.data;
    assign rd_par_err = head.par_err;
    assign rd_frm_err = head.frm_err;
    assign rxd_raw    = rxd;
    assign rts_n      = (rx_level >= LW'(RTS_LEVEL));
endmodule

// File: rtl/srx_chk.sv
`timescale 1ns/1ps
module srx_chk #(
    parameter int DEPTH = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ent_valid,
    input logic                   ent_msb,
    input logic                   cfg_seven,
    input logic                   full,
    input logic                   push,
    input logic                   pop,
    input logic [$clog2(DEPTH):0] level,
    input logic                   overrun,
    input logic                   ovr_clr,
    input logic                   break_det,
    input logic                   rxd_s
);
    localparam int LW = $clog2(DEPTH) + 1;

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_fill_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (level == $past(level) + LW'(1)));

    assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && full) |=> overrun);

    assert_ovr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    assert_seven_msb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && cfg_seven) |-> !ent_msb);

    assert_quiet_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        break_det |-> !ent_valid);

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(break_det) |-> !$past(rxd_s));
endmodule

bind serial_rx_channel srx_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_msb(ent.data[7]),
    .cfg_seven(cfg_seven), .full(rx_full), .push(push), .pop(rd_en),
    .level(rx_level), .overrun(overrun), .ovr_clr(ovr_clr),
    .break_det(break_det), .rxd_s(rxd_s)
);

// File: tb/serial_rx_channel_tb_top.sv
`timescale 1ns/1ps
module serial_rx_channel_tb_top;
    localparam int DEPTH = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, tick_16x, rxd;
    logic cfg_seven, cfg_two_stop, cfg_par_en, cfg_par_odd;
    logic rd_en, ovr_clr;
    logic [7:0] rd_data;
    logic rd_par_err, rd_frm_err, rx_empty, rx_full, overrun, break_det, rxd_raw, rts_n;
    logic [6:0] rx_level;

    serial_rx_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rxd(rxd),
        .cfg_seven(cfg_seven), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rd_en(rd_en), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_frm_err(rd_frm_err), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_level(rx_level), .ovr_clr(ovr_clr), .overrun(overrun),
        .break_det(break_det), .rxd_raw(rxd_raw), .rts_n(rts_n)
    );

    int vectors = 0;
    int miscompares = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    logic [9:0] mq[$];

    initial tick_16x = 1'b0;
    always @(negedge clk) begin
        if (tick_cnt >= tick_div - 1) begin
            tick_cnt = 0;
            tick_16x = 1'b1;
        end else begin
            tick_cnt = tick_cnt + 1;
            tick_16x = 1'b0;
        end
    end

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [9:0] exp_entry(logic [7:0] b, bit sev, bit pen, bit corrupt, bit bad);
        return {pen & corrupt, bad, sev ? {1'b0, b[6:0]} : b};
    endfunction

    function automatic bit par_of(logic [7:0] b, bit sev, bit odd);
        return (sev ? ^b[6:0] : ^b) ^ odd;
    endfunction

    task automatic wait_bits(int n);
        repeat (n * 16 * tick_div) @(negedge clk);
    endtask

    task automatic send_frame(logic [7:0] b, bit corrupt, bit bad1, bit bad2, int hold_low);
        int nd = cfg_seven ? 7 : 8;
        rxd = 1'b0;
        wait_bits(1);
        for (int i = 0; i < nd; i++) begin
            rxd = b[i];
            wait_bits(1);
        end
        if (cfg_par_en) begin
            rxd = par_of(b, cfg_seven, cfg_par_odd) ^ corrupt;
            wait_bits(1);
        end
        rxd = !bad1;
        wait_bits(1);
        if (cfg_two_stop) begin
            rxd = !bad2;
            wait_bits(1);
        end
        if (hold_low > 0) begin
            rxd = 1'b0;
            wait_bits(hold_low);
        end else begin
            rxd = 1'b1;
            wait_bits(1);
        end
        if (mq.size() == DEPTH) ;
        else mq.push_back(exp_entry(b, cfg_seven, cfg_par_en, corrupt,
                                    bad1 | (cfg_two_stop & bad2)));
    endtask

    task automatic read_one;
        logic [9:0] e = mq.pop_front();
        check("R4", "empty before read", rx_empty, 0);
        check("R1", "data", rd_data, e[7:0]);
        check("R2", "frame tag", rd_frm_err, e[8]);
        check("R3", "parity tag", rd_par_err, e[9]);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_fmt(bit sev, bit two, bit pen, bit odd);
        cfg_seven = sev; cfg_two_stop = two; cfg_par_en = pen; cfg_par_odd = odd;
    endtask

    initial begin
        void'($urandom(32'h0000_5A17));
        rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0; ovr_clr = 1'b0;
        set_fmt(0, 0, 0, 0);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check("R10", "empty", rx_empty, 1);
        check("R10", "level", rx_level, 0);
        check("R10", "rts_n", rts_n, 0);
        check("R10", "overrun", overrun, 0);
        check("R10", "break", break_det, 0);

        // R8 raw line level, R9 short glitches
        check("R8", "raw high", rxd_raw, 1);
        rxd = 1'b0;
        #1 check("R8", "raw low", rxd_raw, 0);
        repeat (2) @(negedge clk);
        rxd = 1'b1;
        wait_bits(3);
        check("R9", "glitch 2 ticks", rx_empty, 1);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        wait_bits(3);
        check("R9", "glitch 6 ticks", rx_level, 0);

        // directed formats
        set_fmt(0, 0, 0, 0); send_frame(8'hA5, 0, 0, 0, 0);
        set_fmt(1, 0, 1, 0); send_frame(8'hFF, 0, 0, 0, 0);
        set_fmt(0, 1, 1, 1); send_frame(8'h3C, 1, 0, 0, 0);
        set_fmt(0, 1, 0, 0); send_frame(8'h5A, 0, 1, 0, 0);
        set_fmt(1, 0, 1, 1); send_frame(8'h80, 0, 0, 0, 0);
        check("R4", "level after directed", rx_level, mq.size());
        while (mq.size() > 0) read_one();

        // random formats and errors
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b = 8'($urandom);
            set_fmt($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2);
            tick_div = 1 + ($urandom % 2);
            send_frame(b, ($urandom % 4) == 0, ($urandom % 6) == 0,
                       ($urandom % 6) == 0, 0);
        end
        tick_div = 1;
        wait_bits(1);
        check("R4", "level after random", rx_level, mq.size());
        while (mq.size() > 0) read_one();

        // fill to full, R7 threshold, R5 overrun
        set_fmt(0, 0, 0, 0);
        for (int n = 0; n < DEPTH; n++) begin
            send_frame(8'($urandom), 0, 0, 0, 0);
            if (n == 58) check("R7", "rts at 59", rts_n, 0);
            if (n == 59) check("R7", "rts at 60", rts_n, 1);
        end
        check("R4", "full", rx_full, 1);
        check("R4", "level full", rx_level, 64);
        check("R5", "no overrun yet", overrun, 0);
        send_frame(8'hE7, 0, 0, 0, 0);
        send_frame(8'h18, 0, 0, 0, 0);
        check("R5", "overrun set", overrun, 1);
        check("R5", "level held", rx_level, 64);
        read_one();
        check("R7", "rts at 63", rts_n, 1);
        repeat (4) read_one();
        check("R7", "rts at 59 draining", rts_n, 0);
        check("R5", "overrun sticky", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        check("R5", "overrun cleared", overrun, 0);
        while (mq.size() > 0) read_one();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check("R4", "read empty level", rx_level, 0);
        check("R4", "read empty flag", rx_empty, 1);

        // break detection, 8N1 (frame 10 bits)
        set_fmt(0, 0, 0, 0);
        send_frame(8'h3C, 0, 1, 0, 8);
        check("R6", "short low 8N1", break_det, 0);
        rxd = 1'b1; wait_bits(2);
        read_one();
        send_frame(8'hC3, 0, 1, 0, 12);
        check("R6", "long low 8N1", break_det, 1);
        wait_bits(5);
        check("R6", "no push in break", rx_level, 1);
        rxd = 1'b1;
        repeat (10) @(negedge clk);
        check("R6", "break held under one bit high", break_det, 1);
        wait_bits(2);
        check("R6", "break ends", break_det, 0);
        read_one();
        send_frame(8'h81, 0, 0, 0, 0);
        check("R6", "resume after break", rx_level, 1);
        read_one();

        // break detection, 8O2 (frame 12 bits)
        set_fmt(0, 1, 1, 1);
        send_frame(8'h96, 0, 0, 1, 10);
        check("R6", "short low 8O2", break_det, 0);
        rxd = 1'b1; wait_bits(2);
        read_one();
        send_frame(8'h69, 0, 0, 1, 13);
        check("R6", "long low 8O2", break_det, 1);
        rxd = 1'b1; wait_bits(3);
        check("R6", "break ends 8O2", break_det, 0);
        read_one();

        finish_run();
    end
endmodule